// File: doc/BRIEF.md
# Error-Corrected Dual-Port RAM with Check-Bit Fault Injection

This block is a memory with one write port and one read port, in which every stored word is protected by 8 check bits. A write stores the data word beside the check bits that an internal encoder computes from it. A read recomputes the check bits from the stored data and compares them with the stored ones. The result is a syndrome, and the read port uses it to return corrected data together with status flags that tell a clean read apart from a repaired word and from a word that cannot be repaired.

For testing the decoder, a write can carry a fault: when the inject input is high, an 8-bit mask is XORed into the freshly computed check bits before they are stored. The corrupted word then sits in the array until it is overwritten. Each following read shows how the decoder treats that error pattern. Check bit k has a syndrome with only bit k set. Each data bit has its own distinct 8-bit syndrome of weight five. As a result, any single-bit error in the 40-bit codeword is repaired, and so is any burst of up to three bits confined to the check field. Other patterns are flagged as unrepairable.

The read result appears one clock after the read request and holds until the next request. Addresses not written since reset read back as zero with clean status.

Top module: `ecc_flip_ram`

## Requirements
- R1: While reset is asserted and after it is released, before any read, rd_valid, err_fixed and err_fatal are 0 and rd_data is zero.
- R2: A word written with inj_en low and read back has rd_data equal to the written data, both flags 0, and rd_valid 1. These outputs appear after the clock edge that samples rd_en, and rd_valid is 0 after an edge where rd_en is low.
- R3: A read of an address not written since the last reset returns zero data with both flags 0, including an address that was written before that reset.
- R4: When inj_en is low during a write, inj_mask has no effect and the word reads back clean. A write with inj_en high and an all-zero mask also reads back clean.
- R5: inj_mask bit k flips stored check bit k. A mask with exactly one bit set, at any of the 8 positions, reads back with the written data, err_fixed 1 and err_fatal 0.
- R6: A mask of two adjacent set bits (0x03 shifted left by 0 to 6) reads back with the written data, err_fixed 1 and err_fatal 0.
- R7: A mask of 0x07 shifted left by 0 to 5, or of 0x05 shifted left by 0 to 5, reads back with the written data, err_fixed 1 and err_fatal 0.
- R8: A mask of weight 4, 6, 7 or 8, or of weight 2 or 3 whose set bits span more than three positions (for example 0x13 or 0x81), reads back with err_fatal 1, err_fixed 0 and the stored data bits unmodified.
- R9: A read and a write to the same address at the same clock edge return the contents from before that write.
- R10: While rd_en is low, rd_data, err_fixed and err_fatal hold their last values.
- R11: Overwriting a corrupted word with inj_en low makes later reads of that address clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| inj_en | input | 1 | Fold inj_mask into the stored check bits of this write |
| inj_mask | input | 8 | Bit k flips stored check bit k when inj_en is high |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Corrected read data, one cycle after rd_en |
| rd_valid | output | 1 | High for the cycle after a read request |
| err_fixed | output | 1 | The last read found an error and repaired it |
| err_fatal | output | 1 | The last read found an error it could not repair |

## Verification
A wrong data-bit column in the encoder or decoder shows up on the very first clean read of most data words: err_fixed or err_fatal rises one cycle after rd_en, even though no fault was injected. A mis-entered correction candidate either raises err_fatal for a burst that should be repaired, or returns wrong data with err_fixed set. Either effect is visible on the read that follows the injected write. A stale written-address map turns a read of an unwritten or reset-cleared address into nonzero data one cycle after the request. A faulty output register shows as data or flags changing while rd_en is low.

// File: rtl/ecc_flip_pkg.sv
`timescale 1ns/1ps
package ecc_flip_pkg;

    // Code properties: number of check bits and weight of every data column
    localparam int unsigned CHK_W      = 8;
    localparam int unsigned COL_WEIGHT = 5;
    localparam int unsigned MAX_CW     = 64;

    typedef logic [MAX_CW-1:0] cw_mask_t;

    // Decoder verdict, also the read-status state
    typedef enum logic [1:0] {
        RD_CLEAN = 2'd0,
        RD_FIXED = 2'd1,
        RD_FATAL = 2'd2
    } rd_class_e;

    // idx-th check-bit value of weight COL_WEIGHT in ascending order
    function automatic logic [CHK_W-1:0] data_col(int idx);
        int seen;
        logic [CHK_W-1:0] res;
        seen = 0;
        res  = '0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            logic [CHK_W-1:0] c;
            c = v[CHK_W-1:0];
            if ($countones(c) == COL_WEIGHT) begin
                if (seen == idx) res = c;
                seen++;
            end
        end
        return res;
    endfunction

    // Syndrome of codeword bit b: check bits first, then data bits
    function automatic logic [CHK_W-1:0] code_col(int b);
        if (b < CHK_W) return CHK_W'(1) << b;
        return data_col(b - CHK_W);
    endfunction

    // Correctable patterns: every single bit, then check-field bursts 11, 111, 101
    function automatic int cand_count(int dw);
        return dw + CHK_W + (CHK_W - 1) + 2 * (CHK_W - 2);
    endfunction

    function automatic cw_mask_t cand_mask(int k, int dw);
        int r;
        r = k;
        if (r < dw + CHK_W) return cw_mask_t'(1) << r;
        r = r - (dw + CHK_W);
        if (r < CHK_W - 1) return cw_mask_t'(3) << r;
        r = r - (CHK_W - 1);
        if (r < CHK_W - 2) return cw_mask_t'(7) << r;
        r = r - (CHK_W - 2);
        return cw_mask_t'(5) << r;
    endfunction

    function automatic logic [CHK_W-1:0] cand_syn(int k, int dw);
        cw_mask_t m;
        logic [CHK_W-1:0] s;
        m = cand_mask(k, dw);
        s = '0;
        for (int b = 0; b < dw + CHK_W; b++) begin
            if (m[b]) s = s ^ code_col(b);
        end
        return s;
    endfunction

endpackage

// File: rtl/ecfr_encoder.sv
`timescale 1ns/1ps
module ecfr_encoder
    import ecc_flip_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              flip_en_i,
    input  logic [CHK_W-1:0]  flip_mask_i,
    output logic [CHK_W-1:0]  check_o
);

    logic [CHK_W-1:0] term [DATA_W];

    // One weight-five column per data bit
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [CHK_W-1:0] COL = data_col(i);
        assign term[i] = data_i[i] ? COL : '0;
    end

    always_comb begin
        logic [CHK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            acc = acc ^ term[i];
        end
        check_o = acc ^ (flip_en_i ? flip_mask_i : '0);
    end

endmodule

// File: rtl/ecfr_store.sv
`timescale 1ns/1ps
module ecfr_store #(
    parameter int unsigned CW     = 40,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CW-1:0]     wr_word_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CW-1:0]     rd_word_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [CW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] written_q;

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_word_i;
    end

    // All-zero is a valid codeword, so unwritten words read as zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       written_q <= '0;
        else if (wr_en_i) written_q[wr_addr_i] <= 1'b1;
    end

    // Array read before the edge's write: read-during-write returns old word
    assign rd_word_o = written_q[rd_addr_i] ? mem[rd_addr_i] : '0;

    // R3: a written address is marked from the next cycle on
    p_mark_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> written_q[$past(wr_addr_i)]);

endmodule

// File: rtl/ecfr_decoder.sv
`timescale 1ns/1ps
module ecfr_decoder
    import ecc_flip_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W+CHK_W-1:0] word_i,
    output logic [DATA_W-1:0]       data_o,
    output rd_class_e               cls_o
);

    localparam int unsigned CW    = DATA_W + CHK_W;
    localparam int unsigned NCAND = cand_count(DATA_W);

    logic [CHK_W-1:0]  recomputed;
    logic [CHK_W-1:0]  syndrome;
    logic [NCAND-1:0]  hit;
    logic [DATA_W-1:0] term [NCAND];
    logic [DATA_W-1:0] fix_mask;

    ecfr_encoder #(.DATA_W(DATA_W)) u_recalc (
        .data_i      (word_i[CW-1:CHK_W]),
        .flip_en_i   (1'b0),
        .flip_mask_i ('0),
        .check_o     (recomputed)
    );

    assign syndrome = recomputed ^ word_i[CHK_W-1:0];

    // Syndrome lookup: one comparator per correctable pattern
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam cw_mask_t         MASK = cand_mask(k, DATA_W);
        localparam logic [CHK_W-1:0] SYN  = cand_syn(k, DATA_W);
        assign hit[k]  = (syndrome == SYN);
        assign term[k] = hit[k] ? MASK[CW-1:CHK_W] : '0;
    end

    always_comb begin
        fix_mask = '0;
        for (int k = 0; k < NCAND; k++) begin
            fix_mask = fix_mask | term[k];
        end
        data_o = word_i[CW-1:CHK_W] ^ fix_mask;
        if (syndrome == '0) cls_o = RD_CLEAN;
        else if (|hit)      cls_o = RD_FIXED;
        else                cls_o = RD_FATAL;
    end

endmodule

// File: rtl/ecc_flip_ram.sv
`timescale 1ns/1ps
module ecc_flip_ram
    import ecc_flip_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inj_en,
    input  logic [CHK_W-1:0]  inj_mask,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_fixed,
    output logic              err_fatal
);

    localparam int unsigned CW = DATA_W + CHK_W;

    logic [CHK_W-1:0]  wr_check;
    logic [CW-1:0]     raw_cw;
    logic [DATA_W-1:0] dec_data;
    rd_class_e         dec_cls;

    rd_class_e         cls_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    ecfr_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i      (wr_data),
        .flip_en_i   (inj_en),
        .flip_mask_i (inj_mask),
        .check_o     (wr_check)
    );

    ecfr_store #(.CW(CW), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_word_i ({wr_data, wr_check}),
        .rd_addr_i (rd_addr),
        .rd_word_o (raw_cw)
    );

    ecfr_decoder #(.DATA_W(DATA_W)) u_dec (
        .word_i (raw_cw),
        .data_o (dec_data),
        .cls_o  (dec_cls)
    );

    // Status state register: captures the decoder verdict on each read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q   <= RD_CLEAN;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en;
            if (rd_en) begin
                cls_q  <= dec_cls;
                data_q <= dec_data;
            end
        end
    end

    // Outputs decoded from the status state
    always_comb begin
        rd_data  = data_q;
        rd_valid = valid_q;
        unique case (cls_q)
            RD_CLEAN: begin err_fixed = 1'b0; err_fatal = 1'b0; end
            RD_FIXED: begin err_fixed = 1'b1; err_fatal = 1'b0; end
            RD_FATAL: begin err_fixed = 1'b0; err_fatal = 1'b1; end
            default:  begin err_fixed = 1'b0; err_fatal = 1'b0; end
        endcase
    end

    // R2: a clean word passes to the port unchanged one cycle later
    p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec_cls == RD_CLEAN) |=>
            (rd_data == $past(raw_cw[CW-1:CHK_W]) && !err_fixed && !err_fatal));

    // R2: rd_valid follows the request by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5: a repaired read raises only the repair flag
    p_fixed_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec_cls == RD_FIXED) |=> (err_fixed && !err_fatal));

    // R8: an unrepairable word leaves the data bits untouched
    p_fatal_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec_cls == RD_FATAL) |=>
            (err_fatal && !err_fixed && rd_data == $past(raw_cw[CW-1:CHK_W])));

    // R10: outputs hold without a read request
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(err_fixed) && $stable(err_fatal)));

endmodule

// File: tb/ecc_flip_ram_tb_top.sv
`timescale 1ns/1ps
module ecc_flip_ram_tb_top;

    localparam int WD_CYCLES = 20000;
    localparam int NVEC      = 19;

    typedef struct packed {
        logic [31:0] data;
        logic        inj;
        logic [7:0]  mask;
        logic [1:0]  cls;   // 0 clean, 1 fixed, 2 fatal
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h00000000, 1'b0, 8'h00, 2'd0, 4'd2},  // R2
        '{32'hDEADBEEF, 1'b0, 8'h00, 2'd0, 4'd2},  // R2
        '{32'h12345678, 1'b0, 8'hA5, 2'd0, 4'd4},  // R4 mask ignored
        '{32'hFFFFFFFF, 1'b0, 8'hFF, 2'd0, 4'd4},  // R4 mask ignored
        '{32'hCAFEF00D, 1'b1, 8'h01, 2'd1, 4'd5},  // R5
        '{32'h0F0F0F0F, 1'b1, 8'h80, 2'd1, 4'd5},  // R5
        '{32'h13579BDF, 1'b1, 8'h10, 2'd1, 4'd5},  // R5
        '{32'hA5A5A5A5, 1'b1, 8'h03, 2'd1, 4'd6},  // R6
        '{32'h5A5A5A5A, 1'b1, 8'hC0, 2'd1, 4'd6},  // R6
        '{32'h01234567, 1'b1, 8'h18, 2'd1, 4'd6},  // R6
        '{32'h89ABCDEF, 1'b1, 8'h07, 2'd1, 4'd7},  // R7
        '{32'hFEDCBA98, 1'b1, 8'hE0, 2'd1, 4'd7},  // R7
        '{32'h00FF00FF, 1'b1, 8'h05, 2'd1, 4'd7},  // R7
        '{32'hFF00FF00, 1'b1, 8'hA0, 2'd1, 4'd7},  // R7
        '{32'h11111111, 1'b1, 8'h13, 2'd2, 4'd8},  // R8
        '{32'h22222222, 1'b1, 8'h81, 2'd2, 4'd8},  // R8
        '{32'h33333333, 1'b1, 8'h0F, 2'd2, 4'd8},  // R8
        '{32'h44444444, 1'b1, 8'hFF, 2'd2, 4'd8},  // R8
        '{32'h76543210, 1'b1, 8'h00, 2'd0, 4'd4}   // R4 zero mask
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        inj_en = 1'b0;
    logic [7:0]  inj_mask = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        err_fixed;
    logic        err_fatal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ecc_flip_ram #(.DATA_W(32), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .inj_en    (inj_en),
        .inj_mask  (inj_mask),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .err_fixed (err_fixed),
        .err_fatal (err_fatal)
    );

    task automatic check_val(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            input logic ie, input logic [7:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; inj_en = ie; inj_mask = m;
        @(negedge clk);
        wr_en = 1'b0; inj_en = 1'b0; inj_mask = '0;
    endtask

    // Request at one negedge; the posedge between registers the result
    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [7:0] a,
                               input logic [31:0] exp_data, input logic [1:0] cls,
                               input bit chk_data);
        do_read(a);
        if (chk_data) check_val(req, "rd_data", rd_data, exp_data);
        check_val(req, "rd_valid", {31'd0, rd_valid}, 32'd1);
        check_val(req, "err_fixed", {31'd0, err_fixed}, {31'd0, cls == 2'd1});
        check_val(req, "err_fatal", {31'd0, err_fatal}, {31'd0, cls == 2'd2});
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        for (int c = 0; c < WD_CYCLES; c++) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        check_val("R1", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        check_val("R1", "rd_data in reset", rd_data, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_val("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
        check_val("R1", "rd_data", rd_data, 32'd0);
        check_val("R1", "flags", {30'd0, err_fixed, err_fatal}, 32'd0);

        // R3: unwritten address
        read_expect("R3", 8'd200, 32'd0, 2'd0, 1'b1);

        // Vector table: write every entry, then read every entry back
        for (int i = 0; i < NVEC; i++) begin
            do_write(8'(i), VECS[i].data, VECS[i].inj, VECS[i].mask);
        end
        for (int i = 0; i < NVEC; i++) begin
            read_expect($sformatf("R%0d", VECS[i].req), 8'(i),
                        VECS[i].data, VECS[i].cls, 1'b1);
        end

        // R5: single flip at every check-bit position
        for (int p = 0; p < 8; p++) begin
            do_write(8'(100 + p), 32'h9E3779B9 ^ 32'(p), 1'b1, 8'(1 << p));
            read_expect("R5", 8'(100 + p), 32'h9E3779B9 ^ 32'(p), 2'd1, 1'b1);
        end

        // R6: adjacent pair at every position
        for (int p = 0; p < 7; p++) begin
            do_write(8'(110 + p), 32'h6A09E667 + 32'(p), 1'b1, 8'(3 << p));
            read_expect("R6", 8'(110 + p), 32'h6A09E667 + 32'(p), 2'd1, 1'b1);
        end

        // R7: 111 and 101 spans at every position
        for (int p = 0; p < 6; p++) begin
            do_write(8'(120 + p), 32'hBB67AE85 - 32'(p), 1'b1, 8'(7 << p));
            read_expect("R7", 8'(120 + p), 32'hBB67AE85 - 32'(p), 2'd1, 1'b1);
            do_write(8'(130 + p), 32'h3C6EF372 ^ 32'(p << 4), 1'b1, 8'(5 << p));
            read_expect("R7", 8'(130 + p), 32'h3C6EF372 ^ 32'(p << 4), 2'd1, 1'b1);
        end

        // R10: outputs hold while rd_en is low (last read was a fixed one)
        read_expect("R10", 8'd4, 32'hCAFEF00D, 2'd1, 1'b1);
        @(negedge clk); rd_addr = 8'd14;
        @(negedge clk); rd_addr = 8'd1;
        @(negedge clk);
        check_val("R10", "rd_data hold", rd_data, 32'hCAFEF00D);
        check_val("R10", "err_fixed hold", {31'd0, err_fixed}, 32'd1);
        check_val("R10", "rd_valid idle", {31'd0, rd_valid}, 32'd0);

        // R9: read and write to one address at the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd1; wr_data = 32'h0BADC0DE;
        rd_en = 1'b1; rd_addr = 8'd1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_val("R9", "old data", rd_data, 32'hDEADBEEF);
        read_expect("R9", 8'd1, 32'h0BADC0DE, 2'd0, 1'b1);

        // R11: clean rewrite of a corrupted word
        do_write(8'd14, 32'h11111111, 1'b0, 8'h13);
        read_expect("R11", 8'd14, 32'h11111111, 2'd0, 1'b1);

        // R3: reset forgets written words
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        read_expect("R3", 8'd1, 32'd0, 2'd0, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule